// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM array alive. Leaving reset, it holds every strobe inactive for a programmable power-up pause. It then runs a burst of refresh cycles by itself, with no handshake. Only after that burst does it let normal traffic begin. From then on an interval timer builds up a count of owed refreshes. The block asks the access sequencer for the bus whenever the count is non-zero. When a grant arrives, the block drives the RAS, CAS, WE and address pins itself for one complete refresh cycle.

A build-time parameter chooses the refresh protocol:

- **CAS-before-RAS:** CAS leads RAS, and the device supplies the row.
- **RAS-only:** CAS stays high, and an internal row counter is placed on the address pins.

Owed refreshes may pile up to a parameterised limit, which lets the sequencer postpone them. At the limit the count stops growing and an urgent flag is raised. All timing is counted in clock cycles. The defaults assume a 5 ns clock: a 200 µs pause, eight start-up cycles, a 15.6 µs interval, a 50 ns RAS-low time and an 85 ns total cycle.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `we_n` are high, `busy` is high and `ref_req` is low. No strobe goes low during the first `PAUSE_CYC` cycles after reset is released.
- R2: When the pause ends, exactly `INIT_CNT` refresh cycles run with no regard to `ref_gnt`. During this burst `ref_req` stays low. `busy` first falls only after the last of these cycles has finished its precharge.
- R3: With `RAS_ONLY`=0, `cas_n` is low for exactly `T_CSR` cycles before `ras_n` falls. It stays low for the first `T_CHR` cycles of the RAS-low window and is high for the rest of it. `we_n` is high and `addr` is zero throughout.
- R4: With `RAS_ONLY`=1, `cas_n` never goes low. During every RAS-low window, `addr` holds one constant row number. The row number is 0 for the first cycle after reset, rises by one per refresh (start-up cycles included), and wraps from 2^`ROW_W`-1 to 0.
- R5: Every RAS-low window lasts exactly `T_RAS` cycles. `ras_n` is high for at least `T_RP` cycles between windows.
- R6: Once the start-up burst has been issued, the owed count grows by one every `INTERVAL` cycles. `ref_req` is high exactly when the owed count is non-zero, the start-up burst has been issued and no refresh cycle is in progress.
- R7: A cycle in which `ref_req` and `ref_gnt` are both high starts a refresh in the next cycle and retires one owed refresh. `ref_gnt` has no effect while `ref_req` is low.
- R8: The owed count saturates at `MAX_PEND`. `ref_urgent` is high exactly when the count equals `MAX_PEND`.
- R9: `busy` is high during every refresh cycle, from its first low strobe through the end of its precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Sequencer grants the bus for one refresh |
| ref_req | output | 1 | Refresh owed and block ready to run it |
| ref_urgent | output | 1 | Owed count has reached its limit |
| busy | output | 1 | Block owns the DRAM pins (start-up or refresh cycle) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address in RAS-only mode, zero otherwise |

## Verification
The bench builds the block twice, once for each protocol, with a short pause and interval so that many cycles fit in one run. In the CAS-before-RAS build, the grant is held high through reset and start-up, which shows that the start-up count is not inflated by a grant. The grant is then withheld for five intervals so that the owed count overflows. A later grant must drain exactly the saturated number of refreshes, which separates a saturating counter from a wrapping or unbounded one. The timing of the urgent flag and of the next request is checked to the exact cycle. In the RAS-only build the grant is held high for more than a full sweep of a 4-bit row counter, which exposes errors in the row sequence, in its wrap and in address hold while RAS is low.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CSETUP, PH_STROBE, PH_PRECH} rfs_phase_e;
  typedef enum logic [1:0] {ST_PAUSE, ST_INIT, ST_RUN} rfs_stage_e;
endpackage

// File: rtl/rfs_debt_counter.sv
module rfs_debt_counter #(
  parameter int INTERVAL = 3120,
  parameter int MAX_PEND = 8,
  localparam int TW = $clog2(INTERVAL),
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          take,
  output logic [PW-1:0] pending
);
  logic [TW-1:0] tcnt;
  logic          tick;
  logic          grow;

  assign tick = run && (tcnt == TW'(INTERVAL - 1));
  assign grow = tick && (pending != PW'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      pending <= '0;
    end else begin
      if (!run || tick) tcnt <= '0;
      else              tcnt <= tcnt + 1'b1;
      pending <= pending + PW'(grow) - PW'(take);
    end
  end
endmodule

// File: rtl/rfs_strobe_engine.sv
module rfs_strobe_engine
  import rfs_pkg::*;
#(
  parameter bit RAS_ONLY = 1'b0,
  parameter int ROW_W    = 12,
  parameter int T_CSR    = 2,
  parameter int T_CHR    = 2,
  parameter int T_RAS    = 10,
  parameter int T_RP     = 7,
  localparam int LMAX = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                       : ((T_RP > T_CSR) ? T_RP : T_CSR),
  localparam int CW   = $clog2(LMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             idle,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr
);
  rfs_phase_e    phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          if (RAS_ONLY) begin
            phase <= PH_STROBE;
            cnt   <= CW'(T_RAS - 1);
          end else begin
            phase <= PH_CSETUP;
            cnt   <= CW'(T_CSR - 1);
          end
        end
        PH_CSETUP: if (cnt == '0) begin
          phase <= PH_STROBE;
          cnt   <= CW'(T_RAS - 1);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          phase <= PH_PRECH;
          cnt   <= CW'(T_RP - 1);
        end else cnt <= cnt - 1'b1;
        PH_PRECH: if (cnt == '0) phase <= PH_IDLE;
                  else           cnt   <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle  = (phase == PH_IDLE);
  assign ras_n = (phase != PH_STROBE);

  if (RAS_ONLY) begin : g_row_mode
    logic [ROW_W-1:0] row;
    always_ff @(posedge clk) begin
      if (!rst_n) row <= '0;
      else if (phase == PH_STROBE && cnt == '0) row <= row + 1'b1;
    end
    assign cas_n = 1'b1;
    assign addr  = (phase == PH_STROBE) ? row : '0;
  end else begin : g_cbr_mode
    assign cas_n = !((phase == PH_CSETUP) ||
                     (phase == PH_STROBE && cnt >= CW'(T_RAS - T_CHR)));
    assign addr  = '0;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfs_pkg::*;
#(
  parameter int PAUSE_CYC = 40000,
  parameter int INIT_CNT  = 8,
  parameter int INTERVAL  = 3120,
  parameter int MAX_PEND  = 8,
  parameter bit RAS_ONLY  = 1'b0,
  parameter int ROW_W     = 12,
  parameter int T_CSR     = 2,
  parameter int T_CHR     = 2,
  parameter int T_RAS     = 10,
  parameter int T_RP      = 7,
  localparam int PCW = $clog2(PAUSE_CYC + 1),
  localparam int ICW = $clog2(INIT_CNT + 1),
  localparam int PW  = $clog2(MAX_PEND + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic             busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);
  rfs_stage_e     stage;
  logic [PCW-1:0] pcnt;
  logic [ICW-1:0] icnt;
  logic [PW-1:0]  pending;
  logic           eng_idle;
  logic           start;
  logic           take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= ST_PAUSE;
      pcnt  <= '0;
      icnt  <= '0;
    end else begin
      unique case (stage)
        ST_PAUSE: if (pcnt == PCW'(PAUSE_CYC - 1)) stage <= ST_INIT;
                  else pcnt <= pcnt + 1'b1;
        ST_INIT: if (eng_idle) begin
          icnt <= icnt + 1'b1;
          if (icnt == ICW'(INIT_CNT - 1)) stage <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

  assign ref_req    = (stage == ST_RUN) && eng_idle && (pending != '0);
  assign take       = ref_req && ref_gnt;
  assign start      = ((stage == ST_INIT) && eng_idle) || take;
  assign ref_urgent = (pending == PW'(MAX_PEND));
  assign busy       = (stage != ST_RUN) || !eng_idle;
  assign we_n       = 1'b1;

  rfs_debt_counter #(.INTERVAL(INTERVAL), .MAX_PEND(MAX_PEND)) u_debt (
    .clk(clk), .rst_n(rst_n), .run(stage == ST_RUN), .take(take),
    .pending(pending)
  );

  rfs_strobe_engine #(
    .RAS_ONLY(RAS_ONLY), .ROW_W(ROW_W), .T_CSR(T_CSR), .T_CHR(T_CHR),
    .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(eng_idle),
    .ras_n(ras_n), .cas_n(cas_n), .addr(addr)
  );
endmodule

// File: rtl/rfs_sched_checker.sv
module rfs_sched_checker #(
  parameter bit RAS_ONLY = 1'b0,
  parameter int ROW_W    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             ref_urgent,
  input logic             busy,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] addr
);
  a_r9_busy_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> busy);

  a_r6_req_only_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (ras_n && cas_n));

  a_r7_grant_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (busy && !ref_req));

  a_r8_urgent_is_owed: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (busy || ref_req));

  if (RAS_ONLY) begin : g_ro
    a_r4_row_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $past(!ras_n)) |-> $stable(addr));
  end else begin : g_cbr
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  end
endmodule

bind dram_refresh_sched rfs_sched_checker #(.RAS_ONLY(RAS_ONLY), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_urgent(ref_urgent), .busy(busy), .ras_n(ras_n), .cas_n(cas_n),
  .addr(addr)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
  localparam int PAUSE = 20, INIT = 8, INTV = 100, MAXP = 3, ROWW = 4;
  localparam int TCSR = 2, TCHR = 2, TRAS = 10, TRP = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic c_gnt = 1'b1, c_req, c_urg, c_busy, c_ras, c_cas, c_we;
  logic r_gnt = 1'b1, r_req, r_urg, r_busy, r_ras, r_cas, r_we;
  logic [ROWW-1:0] c_addr, r_addr;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .INTERVAL(INTV),
    .MAX_PEND(MAXP), .RAS_ONLY(1'b0), .ROW_W(ROWW), .T_CSR(TCSR), .T_CHR(TCHR),
    .T_RAS(TRAS), .T_RP(TRP)) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(c_gnt), .ref_req(c_req),
    .ref_urgent(c_urg), .busy(c_busy), .ras_n(c_ras), .cas_n(c_cas),
    .we_n(c_we), .addr(c_addr));

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CNT(INIT), .INTERVAL(INTV),
    .MAX_PEND(MAXP), .RAS_ONLY(1'b1), .ROW_W(ROWW), .T_CSR(TCSR), .T_CHR(TCHR),
    .T_RAS(TRAS), .T_RP(TRP)) i_dram_refresh_sched_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(r_gnt), .ref_req(r_req),
    .ref_urgent(r_urg), .busy(r_busy), .ras_n(r_ras), .cas_n(r_cas),
    .we_n(r_we), .addr(r_addr));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc = 0;
  // CAS-before-RAS monitor state
  int c_falls = 0, c_lo = 0, c_hi = 0, c_caslo = 0;
  bit c_prev = 1'b1, c_init_seen = 1'b0, c_req_early = 1'b0;
  // RAS-only monitor state
  int r_falls = 0, r_lo = 0, r_hi = 0;
  bit r_prev = 1'b1, r_init_seen = 1'b0, r_cas_seen = 1'b0, r_addr_bad = 1'b0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    // ---------- CAS-before-RAS instance ----------
    c_caslo = c_cas ? 0 : c_caslo + 1;
    if (!c_init_seen && c_req) c_req_early = 1'b1;
    if (c_prev && !c_ras) begin
      if (c_falls == 0) chk(cyc > PAUSE, "R1 first strobe cycle", cyc, PAUSE + 1);
      else chk(c_hi >= TRP, "R5 cbr precharge", c_hi, TRP);
      chk(c_caslo - 1 == TCSR, "R3 cas lead before ras", c_caslo - 1, TCSR);
      chk(c_we == 1'b1 && c_addr == '0, "R3 we high addr zero", {c_we, c_addr}, 1 << ROWW);
      chk(c_busy == 1'b1, "R9 busy in cbr cycle", c_busy, 1);
      c_falls++;
      c_lo = 0;
    end
    if (!c_ras) begin
      c_lo++;
      if (c_lo == TCHR) chk(c_cas == 1'b0, "R3 cas hold after ras", c_cas, 0);
      if (c_lo == TCHR + 1) chk(c_cas == 1'b1, "R3 cas released", c_cas, 1);
    end else c_hi = c_prev ? c_hi + 1 : 1;
    if (!c_prev && c_ras) chk(c_lo == TRAS, "R5 cbr ras width", c_lo, TRAS);
    if (!c_init_seen && !c_busy) begin
      c_init_seen = 1'b1;
      chk(c_falls == INIT, "R2 cbr start-up count", c_falls, INIT);
      chk(!c_req_early, "R2 no request during start-up", c_req_early, 0);
      chk(c_ras && c_hi >= TRP, "R2 busy until precharge done", c_hi, TRP);
    end
    c_prev = c_ras;
    // ---------- RAS-only instance ----------
    if (!r_cas) r_cas_seen = 1'b1;
    if (r_prev && !r_ras) begin
      if (r_falls == 0) chk(cyc >= PAUSE, "R1 first ro strobe", cyc, PAUSE + 1);
      else chk(r_hi >= TRP, "R5 ro precharge", r_hi, TRP);
      chk(r_addr == ROWW'(r_falls), "R4 row sequence", r_addr, r_falls % (1 << ROWW));
      chk(r_busy == 1'b1, "R9 busy in ro cycle", r_busy, 1);
      r_falls++;
      r_lo = 0;
    end
    if (!r_ras) begin
      r_lo++;
      if (r_addr != ROWW'(r_falls - 1)) r_addr_bad = 1'b1;
    end else r_hi = r_prev ? r_hi + 1 : 1;
    if (!r_prev && r_ras) chk(r_lo == TRAS, "R5 ro ras width", r_lo, TRAS);
    if (!r_init_seen && !r_busy) begin
      r_init_seen = 1'b1;
      chk(r_falls == INIT, "R2 ro start-up count", r_falls, INIT);
    end
    r_prev = r_ras;
  end

  initial begin
    fork
      begin : main
        int base;
        repeat (3) @(negedge clk);
        chk({c_ras, c_cas, c_we, c_busy, c_req} == 5'b11110, "R1 cbr reset state",
            {c_ras, c_cas, c_we, c_busy, c_req}, 5'b11110);
        chk({r_ras, r_cas, r_we, r_busy, r_req} == 5'b11110, "R1 ro reset state",
            {r_ras, r_cas, r_we, r_busy, r_req}, 5'b11110);
        rst_n = 1'b1;
        do @(negedge clk); while (c_busy);
        c_gnt = 1'b0;
        begin
          int t = 0;
          do begin @(negedge clk); t++; end while (!c_req);
          chk(t <= INTV, "R6 first request after start-up", t, INTV);
        end
        // request observed at T0; further ticks every INTV cycles
        repeat (2 * INTV - 1) @(negedge clk);
        chk(c_urg == 1'b0, "R8 urgent not yet", c_urg, 0);
        @(negedge clk);
        chk(c_urg == 1'b1 && c_req, "R8 urgent at limit", c_urg, 1);
        repeat (2 * INTV + 5) @(negedge clk);
        chk(c_urg == 1'b1, "R8 still saturated", c_urg, 1);
        base = c_falls;
        c_gnt = 1'b1;
        @(negedge clk);
        chk(c_cas == 1'b0 && !c_req && c_busy, "R7 grant starts cycle next clock",
            {c_cas, c_req, c_busy}, 3'b001);
        repeat (84) @(negedge clk);
        chk(c_falls - base == MAXP, "R8 saturated drain count", c_falls - base, MAXP);
        chk(c_req == 1'b0 && c_urg == 1'b0, "R6 request clears when debt paid",
            {c_req, c_urg}, 0);
        c_gnt = 1'b0;
        repeat (9) @(negedge clk);
        chk(c_req == 1'b0, "R6 no request before tick", c_req, 0);
        @(negedge clk);
        chk(c_req == 1'b1, "R6 request at next tick", c_req, 1);
        repeat (1800) @(negedge clk);
        chk(!r_cas_seen, "R4 cas never low in ro", r_cas_seen, 0);
        chk(!r_addr_bad, "R4 row held during ras low", r_addr_bad, 0);
        chk(r_falls >= INIT + (1 << ROWW) + 1, "R4 row wrap covered", r_falls,
            INIT + (1 << ROWW) + 1);
      end
      begin : watchdog
        repeat (100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule